// File: doc/BRIEF.md
# Speculative Reorder Buffer with Operand Renaming

This block is the in-flight instruction window of a small speculative core. Decoded instructions enter at the tail one per cycle. Each source register is replaced on entry either by a value or by the index of the slot that will produce it. Execution units outside the block are offered the oldest instruction whose operands are all values. Their results come back on a single broadcast port, which fills the producing slot and every operand waiting on that slot index.

Retirement is strictly in order from the head. A register is written only when its instruction retires, so the architectural register file never holds speculative state. A conditional branch is resolved when it reaches the head. If the next address chosen at fetch turns out wrong, the whole window is discarded in one cycle and a redirect address is returned to fetch. The window depth is a power-of-two parameter, and the slot index doubles as the rename tag.

Top module: `spec_rob`

## Requirements
- R1: After reset the window is empty: `iss_ready` is 1 and `cm_valid`, `disp_valid` and `redir_valid` are 0. All architectural registers read 0.
- R2: Operation codes on `iss_op` are 0 load-constant, 1 load-own-address, 2 add, 3 memory load, 4 memory store, 5 branch-if-zero. Codes 0 and 1 are complete on entry, with the result `iss_imm` or `iss_ia` respectively.
- R3: A source register is renamed to the youngest live slot that writes it. If that slot already holds its result, the result is captured as a value. If no live slot writes the register, the architectural value is captured.
- R4: A broadcast on `res_valid`/`res_tag`/`res_val` marks the tagged slot complete and replaces that tag with the value in every waiting operand. A broadcast in the same cycle as an entry that references the tag is forwarded into the new slot. An operand that has become a value stays a value.
- R5: `disp_valid` offers the oldest live add, load or store whose two operands are values and whose flag still says waiting. The offer sets the flag to dispatched, so each slot is offered exactly once. `disp_a` is operand 1 (rs1) and `disp_b` is operand 2 (rs2).
- R6: At most one slot retires per cycle, and only the head slot, once it is complete. `cm_valid` pulses with the slot's `cm_ia`. For writing operations (codes 0 to 3), `cm_wr` is 1 and the register `cm_reg` takes `cm_val` at that clock edge.
- R7: A branch at the head retires once both operands are values. Its correct next address is operand 2 if operand 1 is zero, and `ia`+1 otherwise. If this differs from the address given in `iss_pred` at entry, `redir_valid` pulses with `redir_addr` set to the correct address.
- R8: With the parameter `SLOTS` entries live, `iss_ready` is 0 and an offered entry is dropped.
- R9: A redirect empties the window in the same edge. Entries, dispatch and broadcasts in that cycle have no effect, so in the following cycle nothing retires and nothing is offered.
- R10: A store has no result. It retires once it has been dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Entry offered at the tail |
| iss_ready | output | 1 | Entry accepted this cycle |
| iss_ia | input | ADDR_W | Instruction address |
| iss_op | input | 3 | Operation code (R2) |
| iss_rd | input | log2(NREG) | Destination register |
| iss_rs1 | input | log2(NREG) | First source register |
| iss_rs2 | input | log2(NREG) | Second source register |
| iss_imm | input | DATA_W | Constant for load-constant |
| iss_pred | input | ADDR_W | Next address assumed at fetch |
| disp_valid | output | 1 | Instruction offered to execution |
| disp_tag | output | log2(SLOTS) | Slot index of the offered instruction |
| disp_op | output | 3 | Its operation code |
| disp_a | output | DATA_W | Operand 1 value |
| disp_b | output | DATA_W | Operand 2 value |
| res_valid | input | 1 | Result broadcast |
| res_tag | input | log2(SLOTS) | Slot the result belongs to |
| res_val | input | DATA_W | Result value |
| cm_valid | output | 1 | Head slot retires |
| cm_ia | output | ADDR_W | Address of retiring instruction |
| cm_wr | output | 1 | Retirement writes a register |
| cm_reg | output | log2(NREG) | Register written |
| cm_val | output | DATA_W | Value written |
| redir_valid | output | 1 | Mispredicted branch, window flushed |
| redir_addr | output | ADDR_W | Correct next address |

## Verification
The assertions rely on three things about the inputs. Results are broadcast only for live slots that were dispatched. Each such result arrives once. Operation codes 6 and 7 are never entered. The bench meets all three by acting as the execution unit itself: it answers each dispatched add or load with one broadcast in the cycle of the offer, and it never answers a store. It feeds only programs built from the six valid codes, entering instructions only while `iss_ready` is high and no redirect is pending.

// File: rtl/spec_rob_pkg.sv
// Shared operation encoding for the reorder buffer.
// Assumes three bits carry every operation code.
package spec_rob_pkg;

    typedef enum logic [2:0] {
        OP_LDC = 3'd0,
        OP_LPC = 3'd1,
        OP_ADD = 3'd2,
        OP_LD  = 3'd3,
        OP_ST  = 3'd4,
        OP_BRZ = 3'd5
    } rob_op_e;

    // True for operations that produce a register result.
    function automatic logic op_writes(rob_op_e op);
        return (op == OP_LDC) || (op == OP_LPC) || (op == OP_ADD) || (op == OP_LD);
    endfunction

    // True for operations handed to an external execution unit.
    function automatic logic op_exec(rob_op_e op);
        return (op == OP_ADD) || (op == OP_LD) || (op == OP_ST);
    endfunction

endpackage

// File: rtl/spec_rob_regfile.sv
// Architectural register file: two combinational reads, one write.
// Assumes writes come only from in-order retirement.
module spec_rob_regfile #(
    parameter int NREG   = 8,
    parameter int DATA_W = 8,
    parameter int REG_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [REG_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [NREG-1:0][DATA_W-1:0] regs_q;

    // Clear on reset, write the retiring result otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    // Read both source registers.
    always_comb begin
        rdata_a = regs_q[raddr_a];
        rdata_b = regs_q[raddr_b];
    end

endmodule

// File: rtl/spec_rob_rename.sv
// Resolves one source register against the live window.
// Searches from oldest to youngest so the youngest writer wins.
// Assumes SLOTS is a power of two so slot indices wrap naturally.
module spec_rob_rename #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 8,
    parameter int REG_W  = 3,
    parameter int TAG_W  = $clog2(SLOTS)
) (
    input  logic [TAG_W-1:0]              head_idx,
    input  logic [TAG_W:0]                count,
    input  logic [SLOTS-1:0]              has_dst,
    input  logic [SLOTS-1:0][REG_W-1:0]   dst,
    input  logic [SLOTS-1:0]              done,
    input  logic [SLOTS-1:0][DATA_W-1:0]  res,
    input  logic [REG_W-1:0]              src_reg,
    input  logic [DATA_W-1:0]             rf_val,
    input  logic                          bc_valid,
    input  logic [TAG_W-1:0]              bc_tag,
    input  logic [DATA_W-1:0]             bc_val,
    output logic                          opnd_rdy,
    output logic [DATA_W-1:0]             opnd_val,
    output logic [TAG_W-1:0]              opnd_tag
);

    logic             hit;
    logic [TAG_W-1:0] ptag;

    // Find the youngest live producer of the source register.
    always_comb begin
        hit  = 1'b0;
        ptag = '0;
        for (int k = 0; k < SLOTS; k++) begin
            logic [TAG_W-1:0] idx;
            idx = head_idx + TAG_W'(k);
            if ((k < int'(count)) && has_dst[idx] && (dst[idx] == src_reg)) begin
                hit  = 1'b1;
                ptag = idx;
            end
        end
    end

    // Choose architectural value, stored result, forwarded result or tag.
    always_comb begin
        opnd_tag = ptag;
        if (!hit) begin
            opnd_rdy = 1'b1;
            opnd_val = rf_val;
        end else if (done[ptag]) begin
            opnd_rdy = 1'b1;
            opnd_val = res[ptag];
        end else if (bc_valid && (bc_tag == ptag)) begin
            opnd_rdy = 1'b1;
            opnd_val = bc_val;
        end else begin
            opnd_rdy = 1'b0;
            opnd_val = '0;
        end
    end

endmodule

// File: rtl/spec_rob_pick.sv
// Oldest-first selector over the window starting at the head.
// Assumes the eligibility vector already excludes dead slots.
module spec_rob_pick #(
    parameter int SLOTS = 8,
    parameter int TAG_W = $clog2(SLOTS)
) (
    input  logic [TAG_W-1:0] head_idx,
    input  logic [SLOTS-1:0] elig,
    output logic             any,
    output logic [TAG_W-1:0] tag
);

    // Walk youngest to oldest so the oldest eligible slot is kept last.
    always_comb begin
        any = 1'b0;
        tag = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            logic [TAG_W-1:0] idx;
            idx = head_idx + TAG_W'(k);
            if (elig[idx]) begin
                any = 1'b1;
                tag = idx;
            end
        end
    end

endmodule

// File: rtl/spec_rob.sv
// Speculative reorder buffer with slot-index renaming.
// Entries arrive at the tail, take values or producer tags, are offered
// oldest-first to execution, and retire in order from the head.
// A branch is checked at the head; a wrong guess flushes everything.
// Assumes SLOTS is a power of two, DATA_W >= log2(SLOTS), results
// arrive once per dispatched add/load, and only codes 0..5 are entered.
module spec_rob
    import spec_rob_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int NREG   = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int TAG_W  = $clog2(SLOTS),
    parameter int REG_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [ADDR_W-1:0] iss_ia,
    input  logic [2:0]        iss_op,
    input  logic [REG_W-1:0]  iss_rd,
    input  logic [REG_W-1:0]  iss_rs1,
    input  logic [REG_W-1:0]  iss_rs2,
    input  logic [DATA_W-1:0] iss_imm,
    input  logic [ADDR_W-1:0] iss_pred,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [2:0]        disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_val,
    output logic              cm_valid,
    output logic [ADDR_W-1:0] cm_ia,
    output logic              cm_wr,
    output logic [REG_W-1:0]  cm_reg,
    output logic [DATA_W-1:0] cm_val,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr
);

    localparam int PTR_W = TAG_W + 1;
    localparam int NSRC  = 2;

    // Pointers with a wrap bit.
    logic [PTR_W-1:0] head_q, tail_q, count;
    logic [TAG_W-1:0] hidx, tidx;

    // Slot storage.
    logic    [SLOTS-1:0][ADDR_W-1:0]           s_ia;
    rob_op_e [SLOTS-1:0]                       s_op;
    logic    [SLOTS-1:0][NSRC-1:0]             s_rdy;
    logic    [SLOTS-1:0][NSRC-1:0][DATA_W-1:0] s_opv;
    logic    [SLOTS-1:0]                       s_wr;
    logic    [SLOTS-1:0][REG_W-1:0]            s_dst;
    logic    [SLOTS-1:0][ADDR_W-1:0]           s_pred;
    logic    [SLOTS-1:0]                       s_sent;
    logic    [SLOTS-1:0]                       s_done;
    logic    [SLOTS-1:0][DATA_W-1:0]           s_res;

    logic [SLOTS-1:0] live, elig;
    logic             issue, flush, retire, head_done, bc_fire, disp_fire;
    logic             pick_any;
    logic [TAG_W-1:0] pick_tag;
    rob_op_e          h_op, in_op;
    logic [ADDR_W-1:0] br_next;

    logic [NSRC-1:0][REG_W-1:0]  src_reg;
    logic [NSRC-1:0][DATA_W-1:0] rf_rd;
    logic [NSRC-1:0]             rn_rdy;
    logic [NSRC-1:0][DATA_W-1:0] rn_val;
    logic [NSRC-1:0][TAG_W-1:0]  rn_tag;

    assign count  = tail_q - head_q;
    assign hidx   = head_q[TAG_W-1:0];
    assign tidx   = tail_q[TAG_W-1:0];
    assign h_op   = s_op[hidx];
    assign in_op  = rob_op_e'(iss_op);
    assign src_reg[0] = iss_rs1;
    assign src_reg[1] = iss_rs2;

    // Decide whether the head slot has finished.
    always_comb begin
        case (h_op)
            OP_ST:   head_done = s_sent[hidx];
            OP_BRZ:  head_done = &s_rdy[hidx];
            default: head_done = s_done[hidx];
        endcase
    end

    // Resolve the head branch and detect a wrong guess.
    always_comb begin
        br_next = (s_opv[hidx][0] == '0) ? ADDR_W'(s_opv[hidx][1]) : s_ia[hidx] + 1'b1;
        retire  = (count != '0) && head_done;
        flush   = retire && (h_op == OP_BRZ) && (br_next != s_pred[hidx]);
    end

    assign iss_ready = (count != PTR_W'(SLOTS)) && !flush;
    assign issue     = iss_valid && iss_ready;
    assign bc_fire   = res_valid && !flush;

    spec_rob_regfile #(
        .NREG(NREG), .DATA_W(DATA_W), .REG_W(REG_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (retire && s_wr[hidx]),
        .waddr   (s_dst[hidx]),
        .wdata   (s_res[hidx]),
        .raddr_a (src_reg[0]),
        .rdata_a (rf_rd[0]),
        .raddr_b (src_reg[1]),
        .rdata_b (rf_rd[1])
    );

    for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
        spec_rob_rename #(
            .SLOTS(SLOTS), .DATA_W(DATA_W), .REG_W(REG_W), .TAG_W(TAG_W)
        ) u_rn (
            .head_idx (hidx),
            .count    (count),
            .has_dst  (s_wr),
            .dst      (s_dst),
            .done     (s_done),
            .res      (s_res),
            .src_reg  (src_reg[gs]),
            .rf_val   (rf_rd[gs]),
            .bc_valid (bc_fire),
            .bc_tag   (res_tag),
            .bc_val   (res_val),
            .opnd_rdy (rn_rdy[gs]),
            .opnd_val (rn_val[gs]),
            .opnd_tag (rn_tag[gs])
        );
    end

    // Mark live slots and those ready to be offered for execution.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            logic [TAG_W-1:0] off;
            off     = TAG_W'(i) - hidx;
            live[i] = ({1'b0, off} < count);
            elig[i] = live[i] && op_exec(s_op[i]) && !s_sent[i] && (&s_rdy[i]);
        end
    end

    spec_rob_pick #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_pick (
        .head_idx (hidx),
        .elig     (elig),
        .any      (pick_any),
        .tag      (pick_tag)
    );

    assign disp_fire  = pick_any && !flush;
    assign disp_valid = disp_fire;
    assign disp_tag   = pick_tag;
    assign disp_op    = s_op[pick_tag];
    assign disp_a     = s_opv[pick_tag][0];
    assign disp_b     = s_opv[pick_tag][1];

    assign cm_valid    = retire;
    assign cm_ia       = s_ia[hidx];
    assign cm_wr       = s_wr[hidx];
    assign cm_reg      = s_dst[hidx];
    assign cm_val      = s_res[hidx];
    assign redir_valid = flush;
    assign redir_addr  = br_next;

    // Advance pointers, or return both to zero on a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (retire) head_q <= head_q + 1'b1;
            if (issue)  tail_q <= tail_q + 1'b1;
        end
    end

    // Fill the tail slot, capture broadcasts and record dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_sent <= '0;
            s_done <= '0;
            s_rdy  <= '0;
            s_wr   <= '0;
        end else if (!flush) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (issue && (tidx == TAG_W'(i))) begin
                    s_ia[i]   <= iss_ia;
                    s_op[i]   <= in_op;
                    s_wr[i]   <= op_writes(in_op);
                    s_dst[i]  <= iss_rd;
                    s_pred[i] <= iss_pred;
                    s_sent[i] <= 1'b0;
                    s_done[i] <= (in_op == OP_LDC) || (in_op == OP_LPC);
                    s_res[i]  <= (in_op == OP_LPC) ? DATA_W'(iss_ia) : iss_imm;
                    for (int j = 0; j < NSRC; j++) begin
                        s_rdy[i][j] <= rn_rdy[j];
                        s_opv[i][j] <= rn_rdy[j] ? rn_val[j] : DATA_W'(rn_tag[j]);
                    end
                end else begin
                    if (bc_fire && (res_tag == TAG_W'(i))) begin
                        s_done[i] <= 1'b1;
                        s_res[i]  <= res_val;
                    end
                    for (int j = 0; j < NSRC; j++) begin
                        if (!s_rdy[i][j] && bc_fire && (s_opv[i][j][TAG_W-1:0] == res_tag)) begin
                            s_rdy[i][j] <= 1'b1;
                            s_opv[i][j] <= res_val;
                        end
                    end
                    if (disp_fire && (pick_tag == TAG_W'(i))) begin
                        s_sent[i] <= 1'b1;
                    end
                end
            end
        end
    end

    // Assertions
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PTR_W'(SLOTS));                                         // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (count == '0));                                  // R9
    AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (!cm_valid && !disp_valid));                     // R9
    AST_DISP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !(disp_valid && (disp_tag == $past(disp_tag))));  // R5
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (count == PTR_W'(SLOTS)) |-> !iss_ready);                        // R8

    for (genvar ga = 0; ga < SLOTS; ga++) begin : g_hold
        for (genvar gb = 0; gb < NSRC; gb++) begin : g_op
            AST_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (s_rdy[ga][gb] && !(issue && (tidx == TAG_W'(ga)))) |=> s_rdy[ga][gb]); // R4
        end
    end

endmodule

// File: tb/spec_rob_bench.sv
module spec_rob_bench;

    localparam int SLOTS = 4, NREG = 8, DW = 8, AW = 8;
    localparam int TW = 2, RW = 3, PLEN = 16, MAXN = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic iss_valid = 1'b0, iss_ready;
    logic [AW-1:0] iss_ia = '0, iss_pred = '0;
    logic [2:0] iss_op = '0;
    logic [RW-1:0] iss_rd = '0, iss_rs1 = '0, iss_rs2 = '0;
    logic [DW-1:0] iss_imm = '0;
    logic disp_valid;
    logic [TW-1:0] disp_tag;
    logic [2:0] disp_op;
    logic [DW-1:0] disp_a, disp_b;
    logic res_valid = 1'b0;
    logic [TW-1:0] res_tag = '0;
    logic [DW-1:0] res_val = '0;
    logic cm_valid, cm_wr, redir_valid;
    logic [AW-1:0] cm_ia, redir_addr;
    logic [RW-1:0] cm_reg;
    logic [DW-1:0] cm_val;

    int vectors = 0, fails = 0;

    always #2 clk = ~clk;

    spec_rob #(.SLOTS(SLOTS), .NREG(NREG), .DATA_W(DW), .ADDR_W(AW)) u_spec_rob (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_ia(iss_ia), .iss_op(iss_op), .iss_rd(iss_rd), .iss_rs1(iss_rs1),
        .iss_rs2(iss_rs2), .iss_imm(iss_imm), .iss_pred(iss_pred),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .res_valid(res_valid), .res_tag(res_tag),
        .res_val(res_val), .cm_valid(cm_valid), .cm_ia(cm_ia), .cm_wr(cm_wr),
        .cm_reg(cm_reg), .cm_val(cm_val), .redir_valid(redir_valid),
        .redir_addr(redir_addr)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_iss(input int op, input int rd, input int rs1, input int rs2,
                             input int imm, input int ia, input int pred);
        iss_valid = 1'b1; iss_op = 3'(op); iss_rd = RW'(rd); iss_rs1 = RW'(rs1);
        iss_rs2 = RW'(rs2); iss_imm = DW'(imm); iss_ia = AW'(ia); iss_pred = AW'(pred);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; iss_valid = 1'b0; res_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Test program: Fibonacci countdown, then a load, a store and a load-own-address.
    task automatic prog(input int a, input int k, output int op, output int rd,
                        output int rs1, output int rs2, output int imm);
        op = 0; rd = 0; rs1 = 0; rs2 = 0; imm = 0;
        case (a)
            0:  begin rd = 1; imm = k;   end
            1:  begin rd = 2; imm = 0;   end
            2:  begin rd = 3; imm = 1;   end
            3:  begin rd = 7; imm = 255; end
            4:  begin rd = 6; imm = 6;   end
            5:  begin rd = 5; imm = 13;  end
            6:  begin op = 5; rs1 = 1; rs2 = 5; end
            7:  begin op = 2; rd = 4; rs1 = 2; rs2 = 3; end
            8:  begin op = 2; rd = 2; rs1 = 3; rs2 = 0; end
            9:  begin op = 2; rd = 3; rs1 = 4; rs2 = 0; end
            10: begin op = 2; rd = 1; rs1 = 1; rs2 = 7; end
            11: begin op = 5; rs1 = 0; rs2 = 6; end
            12: begin rd = 1; imm = 0; end
            13: begin op = 3; rd = 4; rs1 = 3; rs2 = 0; end
            14: begin op = 4; rs1 = 4; rs2 = 2; end
            default: begin op = 1; rd = 5; end
        endcase
    endtask

    function automatic int pred_of(input int pol, input int ia);
        if (pol == 0) return (ia + 1) & 255;
        if (pol == 1) return (ia == 6) ? 13 : (ia == 11) ? 6 : ia + 1;
        return (ia * 5 + 3) & 15;
    endfunction

    function automatic int mem_of(input int addr);
        return (addr * 3 + 1) & 255;
    endfunction

    int e_ia [MAXN], e_wr [MAXN], e_reg [MAXN], e_val [MAXN];
    int e_n, e_redir;

    // In-order interpreter giving the expected retirement stream.
    task automatic golden(input int k, input int pol);
        int r [NREG];
        int pc, op, rd, rs1, rs2, imm, nx;
        for (int i = 0; i < NREG; i++) r[i] = 0;
        pc = 0; e_n = 0; e_redir = 0;
        while (pc < PLEN && e_n < MAXN) begin
            prog(pc, k, op, rd, rs1, rs2, imm);
            e_ia[e_n] = pc; e_wr[e_n] = 1; e_reg[e_n] = rd; nx = pc + 1;
            case (op)
                0: e_val[e_n] = imm;
                1: e_val[e_n] = pc;
                2: e_val[e_n] = (r[rs1] + r[rs2]) & 255;
                3: e_val[e_n] = mem_of(r[rs1]);
                4: e_wr[e_n] = 0;
                default: begin
                    e_wr[e_n] = 0;
                    nx = (r[rs1] == 0) ? r[rs2] : pc + 1;
                    if (nx != pred_of(pol, pc)) e_redir++;
                end
            endcase
            if (e_wr[e_n] != 0) r[rd] = e_val[e_n];
            e_n++;
            pc = nx;
        end
    endtask

    task automatic run_prog(input int k, input int pol);
        int pc, ci, nred, cyc, op, rd, rs1, rs2, imm;
        logic after_redir;
        golden(k, pol);
        do_reset();
        pc = 0; ci = 0; nred = 0; cyc = 0; after_redir = 1'b0;
        while (ci < e_n && cyc < 600) begin
            @(negedge clk);
            cyc++;
            if (after_redir) begin
                chk("R9", "idle after flush", {cm_valid, disp_valid}, 0);
                after_redir = 1'b0;
            end
            if (cm_valid) begin
                if (ci < MAXN) begin
                    chk("R6", "retire ia", cm_ia, e_ia[ci]);
                    chk("R6", "retire wr", cm_wr, e_wr[ci]);
                    if (e_wr[ci] != 0) begin
                        chk("R3", "retire reg", cm_reg, e_reg[ci]);
                        chk("R2", "retire val", cm_val, e_val[ci]);
                    end
                end
                ci++;
            end
            // Execution unit: answer adds and loads in the cycle of the offer.
            res_valid = 1'b0;
            if (disp_valid && (disp_op == 3'd2 || disp_op == 3'd3)) begin
                res_valid = 1'b1;
                res_tag   = disp_tag;
                res_val   = (disp_op == 3'd2) ? DW'(disp_a + disp_b) : DW'(mem_of(int'(disp_a)));
            end
            iss_valid = 1'b0;
            if (redir_valid) begin
                nred++;
                pc = int'(redir_addr);
                after_redir = 1'b1;
            end else if (iss_ready && pc < PLEN) begin
                prog(pc, k, op, rd, rs1, rs2, imm);
                drive_iss(op, rd, rs1, rs2, imm, pc, (op == 5) ? pred_of(pol, pc) : pc + 1);
                pc = (op == 5) ? pred_of(pol, pc) : pc + 1;
            end
        end
        iss_valid = 1'b0; res_valid = 1'b0;
        chk("R6", "retire count", ci, e_n);
        chk("R7", "redirect count", nred, e_redir);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1", "iss_ready", iss_ready, 1);
        chk("R1", "outputs idle", {cm_valid, disp_valid, redir_valid}, 0);
        // A: r1 = r0 + r0 into slot 0.
        drive_iss(2, 1, 0, 0, 0, 40, 41);
        step();
        chk("R5", "offer A", {disp_valid, disp_tag, disp_a, disp_b}, {1'b1, 2'd0, 8'd0, 8'd0});
        // B: r2 = r1 + r1 entered while A's result 7 is broadcast.
        drive_iss(2, 2, 1, 1, 0, 41, 42);
        res_valid = 1'b1; res_tag = 2'd0; res_val = 8'd7;
        step();
        iss_valid = 1'b0; res_valid = 1'b0;
        chk("R4", "forwarded B", {disp_valid, disp_tag, disp_a, disp_b}, {1'b1, 2'd1, 8'd7, 8'd7});
        chk("R6", "retire A", {cm_valid, cm_wr, cm_reg, cm_val, cm_ia}, {1'b1, 1'b1, 3'd1, 8'd7, 8'd40});
        step();
        chk("R6", "B waits", cm_valid, 0);
        drive_iss(2, 3, 0, 0, 0, 42, 43);
        step();
        drive_iss(2, 4, 0, 0, 0, 43, 44);
        step();
        drive_iss(2, 5, 0, 0, 0, 44, 45);
        step();
        chk("R8", "full", iss_ready, 0);
        drive_iss(0, 6, 0, 0, 99, 45, 46);
        step();
        iss_valid = 1'b0;
        chk("R8", "still full", iss_ready, 0);
        res_valid = 1'b1; res_tag = 2'd1; res_val = 8'd9;
        step();
        res_valid = 1'b0;
        chk("R6", "retire B", {cm_valid, cm_reg, cm_val}, {1'b1, 3'd2, 8'd9});
        step();
        chk("R8", "room again", iss_ready, 1);
        res_valid = 1'b1; res_tag = 2'd2; res_val = 8'd1;
        step();
        chk("R6", "retire C", {cm_valid, cm_reg, cm_val}, {1'b1, 3'd3, 8'd1});
        res_tag = 2'd3; res_val = 8'd2;
        step();
        chk("R6", "retire D", {cm_valid, cm_reg, cm_val}, {1'b1, 3'd4, 8'd2});
        res_tag = 2'd0; res_val = 8'd3;
        step();
        res_valid = 1'b0;
        chk("R6", "retire E", {cm_valid, cm_reg, cm_val}, {1'b1, 3'd5, 8'd3});
        step();
        chk("R8", "dropped entry absent", {cm_valid, disp_valid}, 0);

        // Sweep counter start and guess policy over the test program.
        for (int k = 0; k < 5; k++) begin
            for (int pol = 0; pol < 3; pol++) begin
                run_prog(k, pol);
            end
        end
        // R10: stores retire in the streams above once dispatched (ia 14).
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule